// File: doc/BRIEF.md
# 32-to-64 Bit Stream Widener for Ethernet Transmit

This block sits between a 32-bit streaming source, such as a soft processor's outgoing frame channel, and a 64-bit transmit path feeding a 10G Ethernet MAC. It joins each pair of consecutive 32-bit beats of a frame into one 64-bit word. The earlier beat lands in the upper half and the later beat in the lower half. Each output word carries eight byte enables built from the two beats' keep masks, and an end-of-frame flag.

A frame with an odd number of beats ends on a half-filled word. In that word the upper half holds the last beat, the lower half is zero, and the low four byte enables are clear. Both sides use valid/ready. An input beat is taken when `s_valid` and `s_ready` are both high at a rising clock edge. An output word is taken when `m_valid` and `m_ready` are both high. A completed word stays on the output, unchanged, until the sink accepts it. While it waits, the block refuses input. When the sink takes the word in the same cycle, input flows on without a bubble.

Top module: `stream_widen_32to64`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1 and the next accepted beat is treated as the first (upper) beat of a word.
- R2: Two accepted beats A then B of one frame produce one output word with `m_data[63:32]` = A and `m_data[31:0]` = B.
- R3: The output byte enables are `m_be[7:4]` = keep of the upper beat and `m_be[3:0]` = keep of the lower beat (bit i of keep marks byte i of its beat).
- R4: `m_eof` is 1 on the output word containing the beat accepted with `s_last` = 1 and 0 on every other word.
- R5: A beat accepted with `s_last` = 1 while an upper beat is awaited produces, in the next cycle, a word with that beat in `m_data[63:32]`, `m_data[31:0]` = 0, `m_be` = {its keep, 4'h0} and `m_eof` = 1.
- R6: `s_ready` equals `!m_valid || m_ready`: input is refused exactly while a completed word is waiting and not being taken.
- R7: While `m_valid` is 1 and `m_ready` is 0, the next cycle shows `m_valid` = 1 with `m_data`, `m_be` and `m_eof` unchanged.
- R8: After a frame with an odd beat count, the first beat of the next frame is placed in the upper half of a new word.
- R9: With `s_valid` and `m_ready` held at 1, a frame of n beats is accepted in n consecutive cycles, and its last word has been taken by the cycle after the last beat.
- R10: Cycles with `s_valid` = 0 change nothing: no word is emitted and the pairing position is kept, whatever `s_data`, `s_keep` and `s_last` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat ready |
| s_data | input | 32 | Input beat data |
| s_keep | input | 4 | Input byte keep mask |
| s_last | input | 1 | Last beat of the frame |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output word ready |
| m_data | output | 64 | Output word, earlier beat in the upper half |
| m_be | output | 8 | Output byte enables |
| m_eof | output | 1 | Output word ends the frame |

## Verification
A pairing state stuck in the wrong half shows up on the very next output word. The two beats come out swapped, or a frame's first beat lands in the lower half, or a half-filled word appears where a full one was due. The bench sees this when that word is taken, within one frame. A wrong held-word register or a wrong ready term shows up in the cycle after a stalled handshake, as a changed word or a lost or duplicated beat. The end-of-frame flag and the byte enables are compared on every word, so a misrouted keep or last bit is caught at the first frame it touches.

// File: rtl/wid_pkg.sv
package wid_pkg;
  typedef enum logic {
    RD_UPPER = 1'b0,
    RD_LOWER = 1'b1
  } half_e;
endpackage

// File: rtl/wid_pair_fsm.sv
module wid_pair_fsm #(
  parameter int IN_W   = 32,
  parameter int KEEP_W = IN_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [IN_W-1:0]       beat_data,
  input  logic [KEEP_W-1:0]     beat_keep,
  input  logic                  beat_last,
  output logic                  load,
  output logic [2*IN_W-1:0]     word_data,
  output logic [2*KEEP_W-1:0]   word_be,
  output logic                  word_eof,
  output logic                  in_lower
);
  import wid_pkg::*;

  half_e             st;
  logic [IN_W-1:0]   hi_data;
  logic [KEEP_W-1:0] hi_keep;

  assign in_lower = (st == RD_LOWER);

  always_comb begin
    load     = take && (in_lower || beat_last);
    word_eof = beat_last;
    if (in_lower) begin
      word_data = {hi_data, beat_data};
      word_be   = {hi_keep, beat_keep};
    end else begin
      word_data = {beat_data, {IN_W{1'b0}}};
      word_be   = {beat_keep, {KEEP_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RD_UPPER;
      hi_data <= '0;
      hi_keep <= '0;
    end else if (take) begin
      if (in_lower) begin
        st <= RD_UPPER;
      end else if (!beat_last) begin
        st      <= RD_LOWER;
        hi_data <= beat_data;
        hi_keep <= beat_keep;
      end
    end
  end

  AST_LOWER_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lower && take) |=> !in_lower); // R2
  AST_IDLE_KEEPS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(in_lower)); // R10
endmodule

// File: rtl/wid_out_reg.sv
module wid_out_reg #(
  parameter int W  = 64,
  parameter int BW = W / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  d_data,
  input  logic [BW-1:0] d_be,
  input  logic          d_eof,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [W-1:0]  m_data,
  output logic [BW-1:0] m_be,
  output logic          m_eof,
  output logic          can_load
);
  assign can_load = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_be    <= '0;
      m_eof   <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= d_data;
      m_be    <= d_be;
      m_eof   <= d_eof;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_be) && $stable(m_eof))); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !load); // R6
endmodule

// File: rtl/stream_widen_32to64.sv
module stream_widen_32to64 #(
  parameter int IN_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [IN_W-1:0]       s_data,
  input  logic [IN_W/8-1:0]     s_keep,
  input  logic                  s_last,
  output logic                  m_valid,
  input  logic                  m_ready,
  output logic [2*IN_W-1:0]     m_data,
  output logic [IN_W/4-1:0]     m_be,
  output logic                  m_eof
);
  localparam int KEEP_W = IN_W / 8;
  localparam int OUT_W  = 2 * IN_W;
  localparam int BE_W   = 2 * KEEP_W;

  logic              take, load, in_lower, can_load;
  logic [OUT_W-1:0]  w_data;
  logic [BE_W-1:0]   w_be;
  logic              w_eof;

  assign s_ready = can_load;
  assign take    = s_valid && can_load;

  wid_pair_fsm #(.IN_W(IN_W), .KEEP_W(KEEP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .take(take),
    .beat_data(s_data), .beat_keep(s_keep), .beat_last(s_last),
    .load(load), .word_data(w_data), .word_be(w_be), .word_eof(w_eof),
    .in_lower(in_lower)
  );

  wid_out_reg #(.W(OUT_W), .BW(BE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load),
    .d_data(w_data), .d_be(w_be), .d_eof(w_eof),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .m_be(m_be), .m_eof(m_eof), .can_load(can_load)
  );

  AST_BLOCKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready); // R6
  AST_ODD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last && !in_lower) |=>
      (m_valid && m_eof && m_data[IN_W-1:0] == '0 && m_be[KEEP_W-1:0] == '0)); // R5
  AST_PAIR_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && in_lower) |=> (m_valid && m_data[IN_W-1:0] == $past(s_data))); // R2
  AST_EOF_FROM_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && (in_lower || s_last)) |=> (m_eof == $past(s_last))); // R4
endmodule

// File: tb/sim_stream_widen_32to64.sv
module sim_stream_widen_32to64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic [3:0]  s_keep = '0;
  logic        s_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [63:0] m_data;
  logic [7:0]  m_be;
  logic        m_eof;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] exp_d[$];
  logic [7:0]  exp_b[$];
  logic        exp_e[$];
  logic [31:0] dq[16];
  logic [3:0]  kq[16];

  always #2 clk = ~clk;

  stream_widen_32to64 u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .m_be(m_be), .m_eof(m_eof)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  function automatic logic [63:0] pack_data(input logic [31:0] a, input logic [31:0] b, input bit odd);
    return odd ? {a, 32'h0} : {a, b};
  endfunction

  function automatic logic [7:0] pack_be(input logic [3:0] a, input logic [3:0] b, input bit odd);
    return odd ? {a, 4'h0} : {a, b};
  endfunction

  task automatic build_expect(input int n);
    for (int i = 0; i < n; i += 2) begin
      bit odd = (i + 1 >= n);
      exp_d.push_back(pack_data(dq[i], odd ? 32'h0 : dq[i+1], odd));
      exp_b.push_back(pack_be(kq[i], odd ? 4'h0 : kq[i+1], odd));
      exp_e.push_back(odd ? 1'b1 : (i + 1 == n - 1));
    end
  endtask

  task automatic run_frame(input int n, input bit full, input bit after_odd);
    int sent = 0;
    int cycles = 0;
    bit prev_hold = 0;
    logic [63:0] pd;
    logic [7:0] pb;
    logic pe;
    for (int i = 0; i < n; i++) begin
      dq[i] = $urandom;
      kq[i] = (i == n - 1) ? 4'($urandom % 15 + 1) : 4'hF;
    end
    build_expect(n);
    while (sent < n || exp_d.size() > 0) begin
      @(negedge clk);
      m_ready = full ? 1'b1 : ($urandom % 4 != 0);
      if (sent < n) begin
        s_valid = full ? 1'b1 : ($urandom % 3 != 0);
        s_data  = dq[sent];
        s_keep  = kq[sent];
        s_last  = (sent == n - 1);
      end else begin
        s_valid = 1'b0;
        s_data  = $urandom;
        s_keep  = 4'($urandom);
        s_last  = 1'($urandom);
      end
      #1;
      chk(s_ready == (!m_valid || m_ready), "R6 ready", {63'h0, s_ready}, {63'h0, !m_valid || m_ready});
      if (prev_hold)
        chk(m_valid && m_data == pd && m_be == pb && m_eof == pe, "R7 hold", m_data, pd);
      if (m_valid && m_ready) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R4 extra word", m_data, 64'h0);
        end else begin
          logic [63:0] ed = exp_d.pop_front();
          logic [7:0]  eb = exp_b.pop_front();
          logic        ee = exp_e.pop_front();
          chk(m_data == ed, after_odd ? "R8 R2 data" : "R2 data", m_data, ed);
          chk(m_be == eb, (eb[3:0] == 4'h0) ? "R5 R3 byte enables" : "R3 byte enables", {56'h0, m_be}, {56'h0, eb});
          chk(m_eof == ee, "R4 eof", {63'h0, m_eof}, {63'h0, ee});
        end
      end
      prev_hold = m_valid && !m_ready;
      pd = m_data; pb = m_be; pe = m_eof;
      if (s_valid && s_ready) sent++;
      cycles++;
      if (cycles > 2000) begin
        chk(1'b0, "R6 stalled frame", 64'(sent), 64'(n));
        return;
      end
    end
    if (full)
      chk(cycles == n + 1, "R9 full rate", 64'(cycles), 64'(n + 1));
  endtask

  task automatic idle_check(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      s_valid = 1'b0;
      s_data  = $urandom;
      s_keep  = 4'($urandom);
      s_last  = 1'($urandom);
      m_ready = 1'b1;
      #1;
      chk(!m_valid, "R10 idle no word", {63'h0, m_valid}, 64'h0);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!m_valid, "R1 reset valid", {63'h0, m_valid}, 64'h0);
    chk(s_ready, "R1 reset ready", {63'h0, s_ready}, 64'h1);
    // R1: first frame must start in the upper half
    run_frame(2, 1'b0, 1'b0);
    // R5 single-beat frame, then R8 next frame starts in upper half
    run_frame(1, 1'b0, 1'b0);
    run_frame(4, 1'b0, 1'b1);
    run_frame(3, 1'b0, 1'b0);
    run_frame(5, 1'b0, 1'b1);
    // R10: idle cycles in mid-pairing position handled inside random frames; full idle here
    idle_check(6);
    run_frame(3, 1'b0, 1'b0);
    // R9 full rate frames
    run_frame(8, 1'b1, 1'b1);
    run_frame(7, 1'b1, 1'b0);
    for (int f = 0; f < 200; f++) begin
      int n = $urandom % 12 + 1;
      run_frame(n, 1'b0, 1'b0);
      if (f % 20 == 0) idle_check(2);
    end
    @(negedge clk);
    finish_run();
  end
endmodule